// File: doc/BRIEF.md
# Parallel Camera Input Formatter

This block sits behind a parallel image-sensor port: a pixel clock, a line sync, a frame sync and an 8-bit data bus. It turns the byte stream coming from the sensor into one record per pixel, carrying either luma/chroma fields or red/green/blue fields. It also marks the first pixel of each frame and the first pixel of each line. Colour sensors may deliver YCbCr 4:2:2 or RGB565, and each of these formats supports four byte arrangements. Monochrome sensors may use the full 8-bit bus or only its low four lines, and the order in which the two nibbles arrive can be selected.

The whole block runs on one system clock. The sensor clock is treated as an ordinary input and sampled, and a change of level in the chosen direction marks a bus sample. The sampling edge and the active level of each sync can be configured. Bytes count only while both syncs are in their active state. Bytes that arrive during horizontal or vertical blanking never produce a pixel. The configuration inputs are expected to stay stable for the whole of a frame.

Top module: `camin_formatter`

## Requirements
- R1: With `cfg_pclk_rise`=1, bus samples are taken when `cam_pclk` goes from 0 to 1. With `cfg_pclk_rise`=0, they are taken when it goes from 1 to 0. Data present only at the opposite transition has no effect.
- R2: A sync is active when its level equals its polarity input (`cfg_hs_high` for the line sync, `cfg_vs_high` for the frame sync). 1 means active high and 0 means active low.
- R3: A sample produces pixel data only when both syncs are active and at least one frame-sync inactive sample has been seen since reset. Samples taken in blanking produce no `pix_valid`.
- R4: YCbCr mode (`cfg_rgb`=0, `cfg_mono`=0) groups four bytes. By `cfg_order`, the groups are: 0 = Y0 U Y1 V, 1 = Y0 V Y1 U, 2 = U Y0 V Y1, 3 = V Y0 U Y1. Each group yields two pixels on consecutive cycles, (Y0,U,V) and then (Y1,U,V). The R/G/B outputs are 0.
- R5: RGB565 mode (`cfg_rgb`=1, `cfg_mono`=0) yields one pixel per two bytes (first byte F, second byte S). The `cfg_order` arrangements are: 0: F={R,G[5:3]}, S={G[2:0],B}. 1: F={B,G[5:3]}, S={G[2:0],R}. 2: F={G[2:0],B}, S={R,G[5:3]}. 3: F={G[2:0],R}, S={B,G[5:3]}. Y/U/V are 0.
- R6: Monochrome mode (`cfg_mono`=1) with `cfg_mono4`=0 yields one pixel per byte, with Y set to that byte. U, V, R, G and B are 0.
- R7: With `cfg_mono`=1 and `cfg_mono4`=1, only `cam_data[3:0]` is used. Two samples form one Y byte. With `cfg_nib_swap`=0 the first sample is the upper nibble, and with `cfg_nib_swap`=1 it is the lower nibble.
- R8: The byte position inside a group or nibble pair restarts at every line. Bytes left over at the end of a line are dropped, and the first active byte of the next line is byte 0.
- R9: `pix_sof` is 1 on the first pixel output after a frame-sync inactive period, and on no other pixel of that frame.
- R10: `pix_sol` is 1 on the first pixel of every line, including the first line of a frame.
- R11: While `rst` is high, and in the cycle after it, `pix_valid`, `pix_sof` and `pix_sol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cam_pclk | input | 1 | Sensor pixel clock, sampled as data |
| cam_hsync | input | 1 | Sensor line sync |
| cam_vsync | input | 1 | Sensor frame sync |
| cam_data | input | 8 | Sensor data bus |
| cfg_pclk_rise | input | 1 | 1 = sample on rising pixel-clock change, 0 = falling |
| cfg_hs_high | input | 1 | Line sync active level |
| cfg_vs_high | input | 1 | Frame sync active level |
| cfg_rgb | input | 1 | Colour format: 0 = YCbCr 4:2:2, 1 = RGB565 |
| cfg_order | input | 2 | Byte arrangement selector for colour formats |
| cfg_mono | input | 1 | Monochrome sensor |
| cfg_mono4 | input | 1 | Monochrome on the low four data lines |
| cfg_nib_swap | input | 1 | First nibble goes to the low half when 1 |
| pix_valid | output | 1 | Pixel record valid |
| pix_sof | output | 1 | First pixel of frame |
| pix_sol | output | 1 | First pixel of line |
| pix_y | output | 8 | Luma |
| pix_u | output | 8 | Blue-difference chroma |
| pix_v | output | 8 | Red-difference chroma |
| pix_r | output | 5 | Red |
| pix_g | output | 6 | Green |
| pix_b | output | 5 | Blue |

## Verification
The properties assume that active pixel-clock transitions are at least three system clocks apart. Under that assumption a sample strobe never lasts two cycles, and the second pixel of a YCbCr pair cannot collide with a new byte. They also assume the configuration is changed only while the sensor is idle between frames. The stimulus holds each pixel-clock level for several system clocks. It changes configuration only between frames. It drives inverted data and syncs just before the inactive transition, so that a sampler using the wrong edge produces visibly wrong pixels.

// File: rtl/camin_pkg.sv
package camin_pkg;
  localparam int BYTE_W   = 8;
  localparam int NIB_W    = BYTE_W / 2;
  localparam int YUV_GRP  = 4;
  localparam int PH_W     = $clog2(YUV_GRP);
  localparam int R_W      = 5;
  localparam int G_W      = 6;
  localparam int B_W      = 5;

  typedef struct packed {
    logic              sof;
    logic              sol;
    logic [BYTE_W-1:0] y;
    logic [BYTE_W-1:0] u;
    logic [BYTE_W-1:0] v;
    logic [R_W-1:0]    r;
    logic [G_W-1:0]    g;
    logic [B_W-1:0]    b;
  } pix_t;
endpackage

// File: rtl/camin_sampler.sv
module camin_sampler #(
  parameter int DW = camin_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pclk,
  input  logic          hsync,
  input  logic          vsync,
  input  logic [DW-1:0] din,
  input  logic          cfg_rise,
  input  logic          cfg_hs_high,
  input  logic          cfg_vs_high,
  output logic          smp_vld,
  output logic          smp_frame_act,
  output logic          smp_line_act,
  output logic [DW-1:0] smp_d
);
  logic pclk_q;
  logic hit;
  logic vs_on;
  logic hs_on;

  // an edge is a level change in the selected direction
  assign hit   = cfg_rise ? (pclk & ~pclk_q) : (~pclk & pclk_q);
  assign vs_on = (vsync == cfg_vs_high);
  assign hs_on = (hsync == cfg_hs_high);

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_q        <= pclk;
      smp_vld       <= 1'b0;
      smp_frame_act <= 1'b0;
      smp_line_act  <= 1'b0;
      smp_d         <= '0;
    end else begin
      pclk_q  <= pclk;
      smp_vld <= hit;
      if (hit) begin
        smp_frame_act <= vs_on;
        smp_line_act  <= vs_on & hs_on;
        smp_d         <= din;
      end
    end
  end
endmodule

// File: rtl/camin_unpack.sv
module camin_unpack
  import camin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic              smp_frame_act,
  input  logic              smp_line_act,
  input  logic [BYTE_W-1:0] smp_d,
  input  logic              cfg_rgb,
  input  logic [1:0]        cfg_order,
  input  logic              cfg_mono,
  input  logic              cfg_mono4,
  input  logic              cfg_nib_swap,
  output logic              out_vld,
  output pix_t              out_pix
);
  logic [PH_W-1:0]   phase, phase_nxt;
  logic [BYTE_W-1:0] hold [YUV_GRP-1];
  logic              armed, sof_pend, sol_pend;
  logic              pend2;
  pix_t              rec2_q;

  logic              emit, has2;
  pix_t              rec, rec2;
  logic [BYTE_W-1:0] g0, g1, g2, g3;
  logic [BYTE_W-1:0] hi_b, lo_b, c_a, c_b;
  logic [NIB_W-1:0]  nib_first, nib_now;

  always_comb begin
    emit      = 1'b0;
    has2      = 1'b0;
    rec       = '0;
    rec2      = '0;
    phase_nxt = phase;
    g0 = hold[0]; g1 = hold[1]; g2 = hold[2]; g3 = smp_d;
    hi_b = '0; lo_b = '0; c_a = '0; c_b = '0;
    nib_first = hold[0][NIB_W-1:0];
    nib_now   = smp_d[NIB_W-1:0];
    if (cfg_mono) begin
      if (cfg_mono4) begin
        phase_nxt = {{(PH_W-1){1'b0}}, ~phase[0]};
        if (phase[0]) begin
          emit  = 1'b1;
          rec.y = cfg_nib_swap ? {nib_now, nib_first} : {nib_first, nib_now};
        end
      end else begin
        phase_nxt = '0;
        emit      = 1'b1;
        rec.y     = smp_d;
      end
    end else if (cfg_rgb) begin
      phase_nxt = {{(PH_W-1){1'b0}}, ~phase[0]};
      if (phase[0]) begin
        emit = 1'b1;
        hi_b = cfg_order[1] ? smp_d   : hold[0];
        lo_b = cfg_order[1] ? hold[0] : smp_d;
        rec.g = {hi_b[2:0], lo_b[7:5]};
        rec.r = cfg_order[0] ? lo_b[4:0] : hi_b[7:3];
        rec.b = cfg_order[0] ? hi_b[7:3] : lo_b[4:0];
      end
    end else begin
      phase_nxt = phase + 1'b1;
      if (phase == PH_W'(YUV_GRP-1)) begin
        emit   = 1'b1;
        has2   = 1'b1;
        c_a    = cfg_order[1] ? g0 : g1;
        c_b    = cfg_order[1] ? g2 : g3;
        rec.y  = cfg_order[1] ? g1 : g0;
        rec2.y = cfg_order[1] ? g3 : g2;
        rec.u  = cfg_order[0] ? c_b : c_a;
        rec.v  = cfg_order[0] ? c_a : c_b;
        rec2.u = rec.u;
        rec2.v = rec.v;
      end
    end
    rec.sof = sof_pend;
    rec.sol = sol_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      armed    <= 1'b0;
      sof_pend <= 1'b0;
      sol_pend <= 1'b0;
      pend2    <= 1'b0;
      rec2_q   <= '0;
      out_vld  <= 1'b0;
      out_pix  <= '0;
      for (int i = 0; i < YUV_GRP-1; i++) hold[i] <= '0;
    end else begin
      out_vld <= 1'b0;
      out_pix <= '0;
      if (pend2) begin
        out_vld <= 1'b1;
        out_pix <= rec2_q;
        pend2   <= 1'b0;
      end
      if (smp_vld) begin
        if (!smp_frame_act) begin
          armed    <= 1'b1;
          sof_pend <= 1'b1;
          sol_pend <= 1'b1;
          phase    <= '0;
        end else if (!smp_line_act) begin
          sol_pend <= 1'b1;
          phase    <= '0;
        end else if (armed) begin
          if (phase != PH_W'(YUV_GRP-1)) hold[phase] <= smp_d;
          phase <= phase_nxt;
          if (emit) begin
            out_vld  <= 1'b1;
            out_pix  <= rec;
            sof_pend <= 1'b0;
            sol_pend <= 1'b0;
            pend2    <= has2;
            rec2_q   <= rec2;
          end
        end
      end
    end
  end
endmodule

// File: rtl/camin_formatter.sv
module camin_formatter
  import camin_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cam_pclk,
  input  logic              cam_hsync,
  input  logic              cam_vsync,
  input  logic [DATA_W-1:0] cam_data,
  input  logic              cfg_pclk_rise,
  input  logic              cfg_hs_high,
  input  logic              cfg_vs_high,
  input  logic              cfg_rgb,
  input  logic [1:0]        cfg_order,
  input  logic              cfg_mono,
  input  logic              cfg_mono4,
  input  logic              cfg_nib_swap,
  output logic              pix_valid,
  output logic              pix_sof,
  output logic              pix_sol,
  output logic [BYTE_W-1:0] pix_y,
  output logic [BYTE_W-1:0] pix_u,
  output logic [BYTE_W-1:0] pix_v,
  output logic [R_W-1:0]    pix_r,
  output logic [G_W-1:0]    pix_g,
  output logic [B_W-1:0]    pix_b
);
  logic              smp_vld, smp_frame_act, smp_line_act;
  logic [DATA_W-1:0] smp_d;
  pix_t              pix;

  camin_sampler #(.DW(DATA_W)) u_samp (
    .clk(clk), .rst(rst), .pclk(cam_pclk), .hsync(cam_hsync),
    .vsync(cam_vsync), .din(cam_data), .cfg_rise(cfg_pclk_rise),
    .cfg_hs_high(cfg_hs_high), .cfg_vs_high(cfg_vs_high),
    .smp_vld(smp_vld), .smp_frame_act(smp_frame_act),
    .smp_line_act(smp_line_act), .smp_d(smp_d)
  );

  camin_unpack u_unp (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_frame_act(smp_frame_act),
    .smp_line_act(smp_line_act), .smp_d(smp_d[BYTE_W-1:0]),
    .cfg_rgb(cfg_rgb), .cfg_order(cfg_order), .cfg_mono(cfg_mono),
    .cfg_mono4(cfg_mono4), .cfg_nib_swap(cfg_nib_swap),
    .out_vld(pix_valid), .out_pix(pix)
  );

  assign pix_sof = pix.sof;
  assign pix_sol = pix.sol;
  assign pix_y   = pix.y;
  assign pix_u   = pix.u;
  assign pix_v   = pix.v;
  assign pix_r   = pix.r;
  assign pix_g   = pix.g;
  assign pix_b   = pix.b;
endmodule

// File: rtl/camin_chk.sv
module camin_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_rgb,
  input logic       cfg_mono,
  input logic       smp_vld,
  input logic       pix_valid,
  input logic       pix_sof,
  input logic       pix_sol,
  input logic [7:0] pix_y,
  input logic [7:0] pix_u,
  input logic [7:0] pix_v,
  input logic [4:0] pix_r,
  input logic [5:0] pix_g,
  input logic [4:0] pix_b
);
  // R1
  smp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> !smp_vld);

  // R3
  valid_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> ($past(smp_vld) || $past(pix_valid)));

  // R9
  sof_marks_line_chk: assert property (@(posedge clk) disable iff (rst)
    pix_sof |-> (pix_sol && pix_valid));

  // R10
  sol_needs_pixel_chk: assert property (@(posedge clk) disable iff (rst)
    pix_sol |-> pix_valid);

  // R6
  mono_colour_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && cfg_mono) |->
      (pix_u == 8'd0 && pix_v == 8'd0 && pix_r == 5'd0 && pix_g == 6'd0 && pix_b == 5'd0));

  // R5
  rgb_luma_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && cfg_rgb && !cfg_mono) |->
      (pix_y == 8'd0 && pix_u == 8'd0 && pix_v == 8'd0));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!pix_valid && !pix_sof && !pix_sol));
endmodule

bind camin_formatter camin_chk u_chk (
  .clk(clk), .rst(rst), .cfg_rgb(cfg_rgb), .cfg_mono(cfg_mono),
  .smp_vld(smp_vld), .pix_valid(pix_valid), .pix_sof(pix_sof),
  .pix_sol(pix_sol), .pix_y(pix_y), .pix_u(pix_u), .pix_v(pix_v),
  .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
);

// File: tb/sim_camin_formatter.sv
`timescale 1ns/1ps
module sim_camin_formatter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       cam_pclk = 1'b0, cam_hsync = 1'b0, cam_vsync = 1'b0;
  logic [7:0] cam_data = 8'h00;
  logic       cfg_pclk_rise = 1'b1, cfg_hs_high = 1'b1, cfg_vs_high = 1'b1;
  logic       cfg_rgb = 1'b0, cfg_mono = 1'b0, cfg_mono4 = 1'b0, cfg_nib_swap = 1'b0;
  logic [1:0] cfg_order = 2'd0;
  logic       pix_valid, pix_sof, pix_sol;
  logic [7:0] pix_y, pix_u, pix_v;
  logic [4:0] pix_r, pix_b;
  logic [5:0] pix_g;

  camin_formatter u0 (
    .clk(clk), .rst(rst), .cam_pclk(cam_pclk), .cam_hsync(cam_hsync),
    .cam_vsync(cam_vsync), .cam_data(cam_data), .cfg_pclk_rise(cfg_pclk_rise),
    .cfg_hs_high(cfg_hs_high), .cfg_vs_high(cfg_vs_high), .cfg_rgb(cfg_rgb),
    .cfg_order(cfg_order), .cfg_mono(cfg_mono), .cfg_mono4(cfg_mono4),
    .cfg_nib_swap(cfg_nib_swap), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_sol(pix_sol), .pix_y(pix_y), .pix_u(pix_u), .pix_v(pix_v),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
  );

  int tests = 0;
  int fails = 0;
  int vcount = 0;
  bit finished = 1'b0;

  logic [41:0] exp_q[$];
  string       tag_q[$];

  // behavioural model state
  int         m_ph;
  logic [7:0] m_buf [4];
  bit         m_sof, m_sol;

  task automatic push(input logic [7:0] y, input logic [7:0] u, input logic [7:0] v,
                      input logic [4:0] r, input logic [5:0] g, input logic [4:0] b,
                      input string tag);
    exp_q.push_back({m_sof, m_sol, y, u, v, r, g, b});
    tag_q.push_back(tag);
    m_sof = 1'b0;
    m_sol = 1'b0;
  endtask

  task automatic model_byte(input logic [7:0] bv, input string tag);
    logic [7:0] full;
    int role [4];
    logic [7:0] ya, yb, uu, vv;
    bit first_y;
    if (cfg_mono && !cfg_mono4) begin
      push(bv, 8'd0, 8'd0, 5'd0, 6'd0, 5'd0, tag);
    end else if (cfg_mono) begin
      if (m_ph == 0) begin
        m_buf[0] = bv;
        m_ph = 1;
      end else begin
        full = cfg_nib_swap ? {bv[3:0], m_buf[0][3:0]} : {m_buf[0][3:0], bv[3:0]};
        push(full, 8'd0, 8'd0, 5'd0, 6'd0, 5'd0, tag);
        m_ph = 0;
      end
    end else if (cfg_rgb) begin
      m_buf[m_ph] = bv;
      if (m_ph == 1) begin
        case (cfg_order)
          2'd0: push(0, 0, 0, m_buf[0][7:3], {m_buf[0][2:0], m_buf[1][7:5]}, m_buf[1][4:0], tag);
          2'd1: push(0, 0, 0, m_buf[1][4:0], {m_buf[0][2:0], m_buf[1][7:5]}, m_buf[0][7:3], tag);
          2'd2: push(0, 0, 0, m_buf[1][7:3], {m_buf[1][2:0], m_buf[0][7:5]}, m_buf[0][4:0], tag);
          default: push(0, 0, 0, m_buf[0][4:0], {m_buf[1][2:0], m_buf[0][7:5]}, m_buf[1][7:3], tag);
        endcase
        m_ph = 0;
      end else m_ph = 1;
    end else begin
      m_buf[m_ph] = bv;
      if (m_ph == 3) begin
        case (cfg_order)
          2'd0: role = '{0, 1, 0, 2};
          2'd1: role = '{0, 2, 0, 1};
          2'd2: role = '{1, 0, 2, 0};
          default: role = '{2, 0, 1, 0};
        endcase
        first_y = 1'b1; ya = 0; yb = 0; uu = 0; vv = 0;
        for (int k = 0; k < 4; k++) begin
          if (role[k] == 0) begin
            if (first_y) ya = m_buf[k]; else yb = m_buf[k];
            first_y = 1'b0;
          end else if (role[k] == 1) uu = m_buf[k];
          else vv = m_buf[k];
        end
        push(ya, uu, vv, 0, 0, 0, tag);
        push(yb, uu, vv, 0, 0, 0, tag);
        m_ph = 0;
      end else m_ph = m_ph + 1;
    end
  endtask

  // one bus sample: data valid at the active edge, inverted at the inactive one (R1)
  task automatic send_byte(input logic [7:0] bv, input bit hs_on, input bit vs_on);
    @(negedge clk);
    cam_hsync = hs_on ? cfg_hs_high : !cfg_hs_high;
    cam_vsync = vs_on ? cfg_vs_high : !cfg_vs_high;
    cam_data  = bv;
    cam_pclk  = !cfg_pclk_rise;
    repeat (3) @(negedge clk);
    cam_pclk = cfg_pclk_rise;
    repeat (2) @(negedge clk);
    cam_data  = ~bv;
    cam_hsync = ~cam_hsync;
    cam_vsync = ~cam_vsync;
    repeat (2) @(negedge clk);
    cam_pclk = !cfg_pclk_rise;
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input int lines, input int nb, input int seed, input string tag);
    logic [7:0] bv;
    for (int k = 0; k < 3; k++) send_byte(8'h5A + 8'(k), 1'b0, 1'b0);
    m_sof = 1'b1;
    for (int ln = 0; ln < lines; ln++) begin
      send_byte(8'h11, 1'b0, 1'b1);
      send_byte(8'h22, 1'b0, 1'b1);
      m_sol = 1'b1;
      m_ph = 0;
      for (int i = 0; i < nb; i++) begin
        bv = 8'(seed + ln * 37 + i * 29 + i * i * 3);
        if (cfg_mono && cfg_mono4) bv = {4'hC ^ 4'(i), bv[3:0]};
        model_byte(bv, tag);
        send_byte(bv, 1'b1, 1'b1);
      end
    end
    send_byte(8'h33, 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R3", "pixels still owed after frame", exp_q.size(), 0);
  endtask

  // every clock: compare output against the head of the expected queue
  always @(negedge clk) begin
    if (!rst && pix_valid) begin
      logic [41:0] act;
      act = {pix_sof, pix_sol, pix_y, pix_u, pix_v, pix_r, pix_g, pix_b};
      vcount++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected pixel", int'(act[31:0]), 0);
      end else begin
        logic [41:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e[41:40] != act[41:40])
          check(1'b0, {t, " R9 R10"}, "sof/sol", int'(act[41:40]), int'(e[41:40]));
        else
          check(act == e, t, "pixel {y,u,v,r,g,b}", int'(act[39:0] >> 8), int'(e[39:0] >> 8));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int vbefore;
    repeat (6) @(negedge clk);
    // R11: quiet during reset
    check(!pix_valid && !pix_sof && !pix_sol, "R11", "outputs in reset",
          int'({pix_valid, pix_sof, pix_sol}), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!pix_valid, "R11", "valid after reset", int'(pix_valid), 0);

    // R4 with rising edge sampling (R1) and active-high syncs (R2)
    for (int o = 0; o < 4; o++) begin
      cfg_order = 2'(o);
      run_frame(2, 8, 16 * o + 3, "R4 R1 R2");
    end

    // R5 with falling edge sampling (R1) and active-low syncs (R2)
    @(negedge clk);
    cfg_rgb = 1'b1; cfg_pclk_rise = 1'b0; cfg_hs_high = 1'b0; cfg_vs_high = 1'b0;
    for (int o = 0; o < 4; o++) begin
      cfg_order = 2'(o);
      run_frame(2, 6, 40 * o + 7, "R5 R1 R2");
    end

    // R6 eight-bit monochrome, mixed sync polarity
    @(negedge clk);
    cfg_mono = 1'b1; cfg_pclk_rise = 1'b1; cfg_hs_high = 1'b0; cfg_vs_high = 1'b1;
    run_frame(2, 5, 91, "R6");

    // R7 four-bit monochrome, both nibble orders
    @(negedge clk);
    cfg_mono4 = 1'b1; cfg_nib_swap = 1'b0;
    run_frame(2, 6, 55, "R7");
    @(negedge clk);
    cfg_nib_swap = 1'b1;
    run_frame(2, 6, 77, "R7");
    // R7 + R8: odd nibble count per line
    run_frame(3, 5, 13, "R7 R8");

    // R8 line-start realignment with leftover bytes
    @(negedge clk);
    cfg_mono = 1'b0; cfg_mono4 = 1'b0; cfg_rgb = 1'b1; cfg_order = 2'd1;
    run_frame(3, 5, 101, "R8 R5");
    @(negedge clk);
    cfg_rgb = 1'b0; cfg_order = 2'd2;
    run_frame(3, 6, 67, "R8 R4");

    // R3 blanking samples: line sync active but frame sync idle, and vice versa
    vbefore = vcount;
    for (int k = 0; k < 4; k++) send_byte(8'hA0 + 8'(k), 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) send_byte(8'hB0 + 8'(k), 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    check(vcount == vbefore, "R3", "pixels during blanking", vcount - vbefore, 0);

    // R9 R10: a later frame again starts with sof on its first pixel
    cfg_order = 2'd3;
    run_frame(2, 4, 5, "R9 R10 R4");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule